// File: doc/BRIEF.md
# Extended Feature-Enable Register Write Guard

This block owns a 64-bit feature-enable control register and decides, for each write request, whether the write is legal. A request is a one-cycle valid pulse. It carries a register index and two data halves, each taken from the low bits of a wider source operand. It also carries the processor state at the time of the request: current privilege level, real-address mode, virtual-8086 mode, a flag saying the feature is supported, a flag saying the operating system has enabled it, and a flag saying a lock prefix was present.

One cycle after a request, the block pulses `done`. If the request broke a rule, it also pulses exactly one of two fault outputs, invalid-opcode or general-protection, and leaves the register as it was. If the request was legal, the register takes the new value on the same edge. The register value is always visible on a read port.

Decoding the instruction, delivering the fault and saving or restoring the enabled state belong to neighbouring logic.

Top module: `xcr_write_guard`

## Requirements
- R1: After synchronous reset the register reads 64'h1, and `done`, `fault_ud` and `fault_gp` are 0.
- R2: A legal request loads the register with {hi[31:0], lo[31:0]} on the edge that samples it. One cycle after the request, `done` is 1 with both faults 0. Bits above 31 of the index, high and low source inputs have no effect.
- R3: If `feat_supported` is 0, `os_enable` is 0 or `lock_prefix` is 1, the request raises `fault_ud`. This check wins over every general-protection condition.
- R4: A request made with `v86_mode` set raises `fault_gp`, whatever the privilege level and `real_mode` are.
- R5: A request with privilege level other than 0 raises `fault_gp` unless `real_mode` is 1. In real mode any privilege level is accepted.
- R6: A request whose index (bits 31:0) is not 0 raises `fault_gp`.
- R7: A value with bit 0 equal to 0 raises `fault_gp`.
- R8: A value with bits [2:1] equal to 2'b10 raises `fault_gp`. The combinations 2'b00, 2'b01 and 2'b11 are accepted.
- R9: A value with a 1 in any bit outside the implemented mask (default: bits 2:0) raises `fault_gp`.
- R10: A rejected request leaves the register unchanged, and exactly one fault pulses together with `done`.
- R11: In a cycle that follows no request, `done` and both faults are 0 and the register holds its value. Back-to-back requests each get their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle write request strobe |
| req_index | input | 64 | Register index source; only bits 31:0 are used |
| req_hi | input | 64 | High data source; bits 31:0 form register bits 63:32 |
| req_lo | input | 64 | Low data source; bits 31:0 form register bits 31:0 |
| cpl | input | 2 | Current privilege level |
| real_mode | input | 1 | Processor is in real-address mode |
| v86_mode | input | 1 | Processor is in virtual-8086 mode |
| feat_supported | input | 1 | The feature is present |
| os_enable | input | 1 | The OS has enabled the feature |
| lock_prefix | input | 1 | The request carried a lock prefix |
| xcr_value | output | 64 | Current register contents |
| done | output | 1 | Result pulse, one cycle after a request |
| fault_ud | output | 1 | Invalid-opcode fault pulse |
| fault_gp | output | 1 | General-protection fault pulse |

## Verification
The bench stresses fault priority. A request with several illegal conditions at once must give invalid-opcode only. A design that ordered its checks wrongly would pulse general-protection, or both faults.

The bench also sets garbage in the upper operand bits and a nonzero upper index half. A design that used the full operands would reject legal writes or load corrupt high bits.

Each value rule is probed at its edge: bit 0 cleared, each pattern of bits [2:1], a single reserved bit at the top and at the bottom of the reserved range, and real mode with a nonzero privilege level. A design that mixed up the prerequisite pair or the mode test would accept a forbidden value or refuse a legal one.

Back-to-back requests with a rejected write between two good ones show whether a faulted request disturbs the register or the results of its neighbours.

// File: rtl/xcrw_pkg.sv
package xcrw_pkg;
  typedef enum logic [1:0] {
    VERDICT_OK = 2'd0,
    VERDICT_UD = 2'd1,
    VERDICT_GP = 2'd2
  } verdict_e;
endpackage

// File: rtl/xcrw_mode_gate.sv
module xcrw_mode_gate #(
  parameter int CPL_W = 2
) (
  input  logic [CPL_W-1:0] cpl,
  input  logic             real_mode,
  input  logic             v86_mode,
  input  logic             feat_supported,
  input  logic             os_enable,
  input  logic             lock_prefix,
  output logic             ud_hit,
  output logic             gp_mode_hit
);
  // Opcode-level rejection: feature absent, not enabled, or locked form.
  always_comb begin
    ud_hit = !feat_supported || !os_enable || lock_prefix;
  end

  // Mode-level protection: v86 always refused; otherwise ring 0 or real mode.
  always_comb begin
    gp_mode_hit = v86_mode || ((cpl != '0) && !real_mode);
  end
endmodule

// File: rtl/xcrw_value_gate.sv
module xcrw_value_gate #(
  parameter int                 IDX_W      = 32,
  parameter int                 XCR_W      = 64,
  parameter logic [XCR_W-1:0]   IMPL_MASK  = 64'h7,
  parameter logic [IDX_W-1:0]   IMPL_INDEX = '0
) (
  input  logic [IDX_W-1:0] index,
  input  logic [XCR_W-1:0] value,
  output logic             gp_value_hit
);
  logic bad_index;
  logic bad_base;
  logic bad_pair;
  logic bad_reserved;

  always_comb begin
    bad_index    = (index != IMPL_INDEX);
    bad_base     = !value[0];
    bad_pair     = value[2] && !value[1];
    bad_reserved = |(value & ~IMPL_MASK);
    gp_value_hit = bad_index || bad_base || bad_pair || bad_reserved;
  end
endmodule

// File: rtl/xcr_write_guard.sv
module xcr_write_guard
  import xcrw_pkg::*;
#(
  parameter int                      SRC_W     = 64,
  parameter int                      IDX_W     = 32,
  parameter int                      HALF_W    = 32,
  parameter int                      CPL_W     = 2,
  parameter logic [2*HALF_W-1:0]     IMPL_MASK = 64'h7,
  parameter logic [2*HALF_W-1:0]     RESET_VAL = 64'h1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [SRC_W-1:0]    req_index,
  input  logic [SRC_W-1:0]    req_hi,
  input  logic [SRC_W-1:0]    req_lo,
  input  logic [CPL_W-1:0]    cpl,
  input  logic                real_mode,
  input  logic                v86_mode,
  input  logic                feat_supported,
  input  logic                os_enable,
  input  logic                lock_prefix,
  output logic [2*HALF_W-1:0] xcr_value,
  output logic                done,
  output logic                fault_ud,
  output logic                fault_gp
);
  localparam int XCR_W = 2 * HALF_W;

  logic [IDX_W-1:0] idx_used;
  logic [XCR_W-1:0] new_value;
  logic             ud_hit;
  logic             gp_mode_hit;
  logic             gp_value_hit;
  verdict_e         verdict;

  // Upper source bits are dropped here.
  always_comb begin
    idx_used  = req_index[IDX_W-1:0];
    new_value = {req_hi[HALF_W-1:0], req_lo[HALF_W-1:0]};
  end

  xcrw_mode_gate #(.CPL_W(CPL_W)) u_mode (
    .cpl            (cpl),
    .real_mode      (real_mode),
    .v86_mode       (v86_mode),
    .feat_supported (feat_supported),
    .os_enable      (os_enable),
    .lock_prefix    (lock_prefix),
    .ud_hit         (ud_hit),
    .gp_mode_hit    (gp_mode_hit)
  );

  xcrw_value_gate #(
    .IDX_W     (IDX_W),
    .XCR_W     (XCR_W),
    .IMPL_MASK (IMPL_MASK)
  ) u_value (
    .index        (idx_used),
    .value        (new_value),
    .gp_value_hit (gp_value_hit)
  );

  // Priority: opcode rejection first, then any protection rule.
  always_comb begin
    if (ud_hit)                          verdict = VERDICT_UD;
    else if (gp_mode_hit || gp_value_hit) verdict = VERDICT_GP;
    else                                 verdict = VERDICT_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xcr_value <= RESET_VAL;
      done      <= 1'b0;
      fault_ud  <= 1'b0;
      fault_gp  <= 1'b0;
    end else begin
      done     <= req_valid;
      fault_ud <= req_valid && (verdict == VERDICT_UD);
      fault_gp <= req_valid && (verdict == VERDICT_GP);
      if (req_valid && (verdict == VERDICT_OK)) xcr_value <= new_value;
    end
  end

  assert_single_fault_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fault_ud, fault_gp}) && ((fault_ud || fault_gp) -> done));

  assert_hold_on_fault_R10: assert property (@(posedge clk) disable iff (rst)
    (fault_ud || fault_gp) |-> $stable(xcr_value));

  assert_ud_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (!feat_supported || !os_enable || lock_prefix)) |=> (fault_ud && !fault_gp));

  assert_v86_rejected_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && v86_mode && feat_supported && os_enable && !lock_prefix) |=> fault_gp);

  assert_base_bit_R7: assert property (@(posedge clk) disable iff (rst)
    xcr_value[0]);

  assert_no_bad_pair_R8: assert property (@(posedge clk) disable iff (rst)
    xcr_value[2:1] != 2'b10);

  assert_reserved_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (xcr_value & ~IMPL_MASK) == '0);

  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!done && !fault_ud && !fault_gp));
endmodule

// File: tb/xcr_write_guard_bench.sv
module xcr_write_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_index = '0;
  logic [63:0] req_hi = '0;
  logic [63:0] req_lo = '0;
  logic [1:0]  cpl = '0;
  logic        real_mode = 1'b0;
  logic        v86_mode = 1'b0;
  logic        feat_supported = 1'b1;
  logic        os_enable = 1'b1;
  logic        lock_prefix = 1'b0;
  logic [63:0] xcr_value;
  logic        done;
  logic        fault_ud;
  logic        fault_gp;

  xcr_write_guard u_xcr_write_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
    .req_hi(req_hi), .req_lo(req_lo), .cpl(cpl), .real_mode(real_mode),
    .v86_mode(v86_mode), .feat_supported(feat_supported), .os_enable(os_enable),
    .lock_prefix(lock_prefix), .xcr_value(xcr_value), .done(done),
    .fault_ud(fault_ud), .fault_gp(fault_gp)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    logic        ud;
    logic        gp;
    logic [63:0] val;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [63:0] model = 64'h1;
  logic [63:0] seen = 64'h1;
  bit          running = 0;
  bit          finished = 0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] idx, input logic [63:0] hi, input logic [63:0] lo,
                      input logic [1:0] pl, input logic rm, input logic vm,
                      input logic fs, input logic oe, input logic lk, input string tag);
    item_t it;
    logic [63:0] v;
    v = {hi[31:0], lo[31:0]};
    it.ud = 0; it.gp = 0;
    if (!fs || !oe || lk) it.ud = 1;
    else if (vm) it.gp = 1;
    else if (pl != 0 && !rm) it.gp = 1;
    else if (idx[31:0] != 0) it.gp = 1;
    else if (!v[0] || v[2:1] == 2'b10 || (v & ~64'h7) != 0) it.gp = 1;
    else model = v;
    it.val = model; it.due = cyc + 1; it.tag = tag;
    sb_q.push_back(it);
    req_valid = 1; req_index = idx; req_hi = hi; req_lo = lo; cpl = pl;
    real_mode = rm; v86_mode = vm; feat_supported = fs; os_enable = oe; lock_prefix = lk;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    req_index = '1; req_hi = '1; req_lo = '0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the item due this cycle, otherwise expects silence (R11).
  always @(negedge clk) begin
    if (running) begin
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        item_t it;
        it = sb_q.pop_front();
        check(done == 1'b1, it.tag, "done", {63'd0, done}, 64'd1);
        check(fault_ud == it.ud, it.tag, "fault_ud", {63'd0, fault_ud}, {63'd0, it.ud});
        check(fault_gp == it.gp, it.tag, "fault_gp", {63'd0, fault_gp}, {63'd0, it.gp});
        check(xcr_value == it.val, it.tag, "value", xcr_value, it.val);
        seen = it.val;
      end else begin
        check({done, fault_ud, fault_gp} == 3'b000, "R11", "idle pulses",
              {61'd0, done, fault_ud, fault_gp}, 64'd0);
        check(xcr_value == seen, "R11", "idle hold", xcr_value, seen);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(xcr_value == 64'h1, "R1", "reset value", xcr_value, 64'h1);
    check({done, fault_ud, fault_gp} == 3'b000, "R1", "reset pulses",
          {61'd0, done, fault_ud, fault_gp}, 64'd0);
    running = 1;

    send(64'd0, 64'd0, 64'h7, 2'd0, 0, 0, 1, 1, 0, "R2 write 7");
    idle(1);
    send(64'd0, 64'd0, 64'h3, 2'd0, 0, 0, 1, 1, 0, "R8 pair 01");
    send(64'd0, 64'd0, 64'h1, 2'd0, 0, 0, 1, 1, 0, "R8 pair 00");
    send(64'hFFFF_0000_0000_0000, 64'hDEAD_BEEF_0000_0000, 64'hA5A5_0000_0000_0007,
         2'd0, 0, 0, 1, 1, 0, "R2 upper ignored");
    idle(2);
    send(64'd0, 64'd0, 64'h1, 2'd0, 0, 0, 0, 1, 0, "R3 no feature");
    send(64'd0, 64'd0, 64'h1, 2'd0, 0, 0, 1, 0, 0, "R3 os off");
    send(64'd0, 64'd0, 64'h1, 2'd0, 0, 0, 1, 1, 1, "R3 lock");
    send(64'd5, 64'h1, 64'h4, 2'd3, 0, 1, 1, 1, 1, "R3 priority");
    send(64'd0, 64'd0, 64'h3, 2'd0, 0, 1, 1, 1, 0, "R4 v86 ring0");
    send(64'd0, 64'd0, 64'h3, 2'd0, 1, 1, 1, 1, 0, "R4 v86 real");
    send(64'd0, 64'd0, 64'h3, 2'd3, 0, 0, 1, 1, 0, "R5 ring3");
    send(64'd0, 64'd0, 64'h3, 2'd1, 0, 0, 1, 1, 0, "R5 ring1");
    send(64'd0, 64'd0, 64'h3, 2'd3, 1, 0, 1, 1, 0, "R5 real ring3");
    send(64'd1, 64'd0, 64'h7, 2'd0, 0, 0, 1, 1, 0, "R6 index 1");
    send(64'h8000_0000, 64'd0, 64'h7, 2'd0, 0, 0, 1, 1, 0, "R6 index top");
    send(64'd0, 64'd0, 64'h6, 2'd0, 0, 0, 1, 1, 0, "R7 bit0 clear");
    send(64'd0, 64'd0, 64'h5, 2'd0, 0, 0, 1, 1, 0, "R8 pair 10");
    send(64'd0, 64'd0, 64'hF, 2'd0, 0, 0, 1, 1, 0, "R9 bit3");
    send(64'd0, 64'h8000_0000, 64'h7, 2'd0, 0, 0, 1, 1, 0, "R9 bit63");
    send(64'd0, 64'd0, 64'h1, 2'd0, 0, 0, 1, 1, 0, "R10 good a");
    send(64'd0, 64'd0, 64'h4, 2'd0, 0, 0, 1, 1, 0, "R10 bad mid");
    send(64'd0, 64'd0, 64'h7, 2'd0, 0, 0, 1, 1, 0, "R10 good b");
    idle(3);
    finish_run();
  end
endmodule